// File: doc/BRIEF.md
# Multiplexed Sample Input Select and Format Stage

This block is the first stage of a down-converter channel. It selects one of four parallel 17-bit sample buses, or a test word written by a processor. It can pick a single channel out of a time-multiplexed stream of up to eight channels. It turns the incoming code into a 16-bit twos-complement sample. It then presents that sample with a sample-enable, paced either in gated form or in zero-stuffed interpolated form.

Each bus has its own enable pin, which is active low. The stage stays silent after reset until the first sync pulse arrives, either the global sync or one of four local syncs. A small register-write port sets the source, the timing mode, the code format and the channel delay. It also loads the test word and its enable controls.

A two-state controller governs start-up. `ST_WAIT_SYNC` is the reset state. In it, enables are ignored and the outputs stay at zero. The transition `SYNC_SEEN` moves it to `ST_RUN` on the clock edge where the selected sync is high. `ST_RUN` loops on itself (`STAY_RUN`) until reset.

Top module: `ddc_input_select`

## Requirements
- R1: While reset is low, `smp_vld` and `smp_out` are 0. Reset selects bus A, gated timing, twos-complement fixed-point format, delay 0 and the global sync, and it returns the controller to `ST_WAIT_SYNC`.
- R2: Register 0 bits [2:0] select the source. Values 0 to 3 pick bus A to D, where bus k occupies `bus_data[17k+16:17k]` and uses enable `bus_en_n[k]`. Values 4 to 7 pick the test word.
- R3: A bus enable pin counts as asserted when it is 0 and as deasserted when it is 1.
- R4: In gated timing (register 0 bit 3 = 0), `smp_vld` is high exactly for accepted enables, with one output per accepted enable. `smp_out` holds its value while `smp_vld` is low.
- R5: In interpolated timing (register 0 bit 3 = 1), `smp_vld` is high on every clock once running. `smp_out` is 0 for any clock whose enable was not asserted.
- R6: Register 0 bit 9 = 0 uses `sync_glb`. Bit 9 = 1 uses `sync_loc[k]`, where k is register 0 bits [11:10]. An enable is accepted only in cycles after the cycle in which the selected sync was first high, and the running state persists until reset.
- R7: With register 0 bits [8:6] = N and a one-clock enable aligned with channel 0 of a frame, the sample from N clocks after that enable is captured. For N > 0 it is output at the next accepted enable. For N = 0 the sample presented with the enable itself is output.
- R8: Fixed-point samples are `bus[16:1]`. With register 0 bit 4 = 1 (offset binary), bit 16 is inverted to give twos complement.
- R9: With register 0 bit 5 = 1, the sample is floating point: a 14-bit mantissa `bus[16:3]` and an exponent `bus[2:0]`. The mantissa MSB is inverted when offset binary is set. The output is mantissa × 2^exponent, saturated to the range −32768 to 32767.
- R10: The test word comes from register 1 (word bits [16:1]) and register 2 bit 0 (word bit 0). Register 3 bit 0 is a level enable. Writing register 3 with bit 1 = 1 produces a single-clock enable in the next cycle.
- R11: Outputs follow the port inputs of a given cycle two clock edges later. A register write takes effect in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 68 | Four 17-bit sample buses, bus A in the low bits |
| bus_en_n | input | 4 | Per-bus sample enables, active low |
| sync_glb | input | 1 | Global sync pulse |
| sync_loc | input | 4 | Local sync pulses |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| smp_out | output | 16 | Twos-complement sample |
| smp_vld | output | 1 | Sample enable toward the next stage |

## Verification
Channel selection from a multiplexed frame is the hardest behaviour to reach, because the sample that shows up depends on an enable seen in the previous frame. The delayed capture must land on the right clock inside an eight-clock frame. The stimulus builds frames on bus A in which every slot carries a distinct code and only slot 0 carries the enable. It sweeps the delay from 0 to 7, idling between settings so that no stale enable is left in the delay line. A behavioural model predicts each captured slot, and the output is compared against that model on every clock.

// File: rtl/din_pkg.sv
package din_pkg;

    localparam int DIN_MAX_CH  = 8;
    localparam int DIN_DLY_W   = $clog2(DIN_MAX_CH);
    localparam int DIN_SYNC_N  = 4;
    localparam int DIN_SYNC_IW = $clog2(DIN_SYNC_N);

    typedef enum logic [0:0] {
        ST_WAIT_SYNC = 1'b0,
        ST_RUN       = 1'b1
    } din_state_e;

    typedef struct packed {
        logic [2:0]             src;
        logic                   interp;
        logic                   offs_bin;
        logic                   flt;
        logic [DIN_DLY_W-1:0]   chan_dly;
        logic                   use_local;
        logic [DIN_SYNC_IW-1:0] local_idx;
    } din_cfg_t;

endpackage

// File: rtl/din_cfg_regs.sv
module din_cfg_regs
    import din_pkg::*;
#(
    parameter int BUS_W  = 17,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-2:0]  wdata,
    output din_cfg_t          cfg,
    output logic [BUS_W-1:0]  tst_word,
    output logic              tst_level,
    output logic              tst_pulse
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TWORD = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TLSB  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_TCTL  = ADDR_W'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            tst_word  <= '0;
            tst_level <= 1'b0;
            tst_pulse <= 1'b0;
        end else begin
            tst_pulse <= 1'b0;
            if (we) begin
                unique case (addr)
                    A_CTRL: begin
                        cfg.src       <= wdata[2:0];
                        cfg.interp    <= wdata[3];
                        cfg.offs_bin  <= wdata[4];
                        cfg.flt       <= wdata[5];
                        cfg.chan_dly  <= wdata[6 +: DIN_DLY_W];
                        cfg.use_local <= wdata[9];
                        cfg.local_idx <= wdata[10 +: DIN_SYNC_IW];
                    end
                    A_TWORD: tst_word[BUS_W-1:1] <= wdata;
                    A_TLSB:  tst_word[0]         <= wdata[0];
                    A_TCTL: begin
                        tst_level <= wdata[0];
                        tst_pulse <= wdata[1];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/din_src_sel.sv
module din_src_sel #(
    parameter int NUM_BUS = 4,
    parameter int BUS_W   = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BUS*BUS_W-1:0] bus_data,
    input  logic [NUM_BUS-1:0]       bus_en_n,
    input  logic [2:0]               src,
    input  logic [BUS_W-1:0]         tst_word,
    input  logic                     tst_en,
    input  logic                     run,
    output logic [BUS_W-1:0]         smp_q,
    output logic                     en_q,
    output logic                     act_q
);

    logic [BUS_W-1:0]   bus_arr [NUM_BUS];
    logic [NUM_BUS-1:0] bus_en;
    logic [BUS_W-1:0]   sel_raw;
    logic               sel_en;

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        assign bus_arr[g] = bus_data[g*BUS_W +: BUS_W];
        assign bus_en[g]  = ~bus_en_n[g];
    end

    always_comb begin
        sel_raw = tst_word;
        sel_en  = tst_en;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (32'(src) == i) begin
                sel_raw = bus_arr[i];
                sel_en  = bus_en[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
            en_q  <= 1'b0;
            act_q <= 1'b0;
        end else begin
            smp_q <= sel_raw;
            en_q  <= sel_en & run;
            act_q <= run;
        end
    end

endmodule

// File: rtl/din_chan_pick.sv
module din_chan_pick #(
    parameter int BUS_W  = 17,
    parameter int MAX_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUS_W-1:0]          smp_q,
    input  logic                      en_q,
    input  logic [$clog2(MAX_CH)-1:0] dly,
    output logic [BUS_W-1:0]          pick
);

    localparam int DLY_W = $clog2(MAX_CH);

    logic [MAX_CH-2:0] en_sh;
    logic [MAX_CH-1:0] dline;
    logic [BUS_W-1:0]  sel_q;
    logic              cap;

    assign dline = {en_sh, en_q};
    assign cap   = (dly != DLY_W'(0)) && dline[dly];
    assign pick  = (dly == DLY_W'(0)) ? smp_q : sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_sh <= '0;
            sel_q <= '0;
        end else begin
            en_sh <= {en_sh[MAX_CH-3:0], en_q};
            if (cap) begin
                sel_q <= smp_q;
            end
        end
    end

endmodule

// File: rtl/din_fmt.sv
module din_fmt #(
    parameter int BUS_W = 17,
    parameter int OUT_W = 16,
    parameter int EXP_W = 3
) (
    input  logic [BUS_W-1:0] raw,
    input  logic             offs_bin,
    input  logic             flt,
    output logic [OUT_W-1:0] val
);

    localparam int MANT_W = BUS_W - EXP_W;
    localparam int WIDE_W = MANT_W + (1 << EXP_W) - 1;
    localparam logic signed [WIDE_W-1:0] SAT_HI =
        {{(WIDE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] SAT_LO =
        {{(WIDE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0]         fx;
    logic [MANT_W-1:0]        mant;
    logic [EXP_W-1:0]         expo;
    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] shifted;
    logic [OUT_W-1:0]         fl;

    assign fx      = raw[BUS_W-1 -: OUT_W] ^ {offs_bin, {(OUT_W-1){1'b0}}};
    assign mant    = raw[BUS_W-1 -: MANT_W] ^ {offs_bin, {(MANT_W-1){1'b0}}};
    assign expo    = raw[EXP_W-1:0];
    assign wide    = {{(WIDE_W-MANT_W){mant[MANT_W-1]}}, mant};
    assign shifted = wide <<< expo;

    always_comb begin
        if (shifted > SAT_HI) begin
            fl = SAT_HI[OUT_W-1:0];
        end else if (shifted < SAT_LO) begin
            fl = SAT_LO[OUT_W-1:0];
        end else begin
            fl = shifted[OUT_W-1:0];
        end
    end

    assign val = flt ? fl : fx;

endmodule

// File: rtl/ddc_input_select.sv
module ddc_input_select
    import din_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter int BUS_W   = 17,
    parameter int OUT_W   = 16,
    parameter int EXP_W   = 3,
    parameter int ADDR_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BUS*BUS_W-1:0] bus_data,
    input  logic [NUM_BUS-1:0]       bus_en_n,
    input  logic                     sync_glb,
    input  logic [DIN_SYNC_N-1:0]    sync_loc,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [BUS_W-2:0]         cfg_wdata,
    output logic [OUT_W-1:0]         smp_out,
    output logic                     smp_vld
);

    din_cfg_t         cfg_q;
    logic [BUS_W-1:0] tst_word;
    logic             tst_level;
    logic             tst_pulse;
    logic [BUS_W-1:0] smp_q;
    logic             en_q;
    logic             act_q;
    logic [BUS_W-1:0] pick;
    logic [OUT_W-1:0] fmt_val;
    logic             mode_interp;
    logic             sync_hit;
    logic             run;
    din_state_e       st_q;
    din_state_e       st_d;

    assign mode_interp = cfg_q.interp;

    din_cfg_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .cfg       (cfg_q),
        .tst_word  (tst_word),
        .tst_level (tst_level),
        .tst_pulse (tst_pulse)
    );

    // Start-up controller: silent until the chosen sync is seen.
    assign sync_hit = cfg_q.use_local ? sync_loc[cfg_q.local_idx] : sync_glb;
    assign run      = (st_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAIT_SYNC;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT_SYNC: if (sync_hit) st_d = ST_RUN;   // SYNC_SEEN
            ST_RUN:       st_d = ST_RUN;                 // STAY_RUN
            default:      st_d = ST_WAIT_SYNC;
        endcase
    end

    din_src_sel #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_data (bus_data),
        .bus_en_n (bus_en_n),
        .src      (cfg_q.src),
        .tst_word (tst_word),
        .tst_en   (tst_level | tst_pulse),
        .run      (run),
        .smp_q    (smp_q),
        .en_q     (en_q),
        .act_q    (act_q)
    );

    din_chan_pick #(.BUS_W(BUS_W), .MAX_CH(DIN_MAX_CH)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_q (smp_q),
        .en_q  (en_q),
        .dly   (cfg_q.chan_dly),
        .pick  (pick)
    );

    din_fmt #(.BUS_W(BUS_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_fmt (
        .raw      (pick),
        .offs_bin (cfg_q.offs_bin),
        .flt      (cfg_q.flt),
        .val      (fmt_val)
    );

    // Output process: gated holds, interpolated stuffs zeros.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_out <= '0;
            smp_vld <= 1'b0;
        end else if (mode_interp) begin
            smp_vld <= act_q;
            smp_out <= en_q ? fmt_val : '0;
        end else begin
            smp_vld <= en_q;
            if (en_q) begin
                smp_out <= fmt_val;
            end
        end
    end

endmodule

// File: rtl/din_checker.sv
module din_checker #(
    parameter int OUT_W  = 16,
    parameter int ADDR_W = 2,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_run,
    input logic              en_q,
    input logic              interp,
    input logic              tst_pulse,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DW-1:0]     cfg_wdata,
    input logic              smp_vld,
    input logic [OUT_W-1:0]  smp_out
);

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_run |=> ##1 !smp_vld);                                      // R6

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_run |=> st_run);                                             // R6

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(interp) && !smp_vld) |-> $stable(smp_out));             // R4

    AST_INTERP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(interp) && !$past(en_q)) |-> (smp_out == '0));           // R5

    AST_GATED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(interp) |-> (smp_vld == $past(en_q)));                   // R11

    AST_TEST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_pulse && !(cfg_we && cfg_addr == ADDR_W'(3) && cfg_wdata[1]))
        |=> !tst_pulse);                                                // R10

endmodule

bind ddc_input_select din_checker #(
    .OUT_W  (OUT_W),
    .ADDR_W (ADDR_W),
    .DW     (BUS_W-1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_run    (run),
    .en_q      (en_q),
    .interp    (mode_interp),
    .tst_pulse (tst_pulse),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .smp_vld   (smp_vld),
    .smp_out   (smp_out)
);

// File: tb/tb_ddc_input_select.sv
`timescale 1ns/1ps
module tb_ddc_input_select;

    localparam int NB    = 4;
    localparam int BW    = 17;
    localparam int DEPTH = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*BW-1:0]  bus_data = '0;
    logic [NB-1:0]     bus_en_n = '1;
    logic              sync_glb = 1'b0;
    logic [3:0]        sync_loc = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       smp_out;
    logic              smp_vld;

    always #4 clk = ~clk;

    ddc_input_select dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_en_n(bus_en_n),
        .sync_glb(sync_glb), .sync_loc(sync_loc), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .smp_out(smp_out), .smp_vld(smp_vld)
    );

    int    errs = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural mirror of the register settings
    int          m_src = 0, m_dly = 0, m_lidx = 0;
    bit          m_interp = 0, m_offs = 0, m_flt = 0, m_uloc = 0, m_tlev = 0;
    logic [16:0] m_tword = '0;
    bit          run_m = 0, pulse_m = 0;
    logic [16:0] sel_cur = '0;
    int          prev_out = 0;

    logic [16:0] raw_h [DEPTH];
    logic [16:0] sel_h [DEPTH];
    bit          acc_h [DEPTH];
    bit          run_h [DEPTH];
    bit          int_h [DEPTH];
    bit          offs_h [DEPTH];
    bit          flt_h [DEPTH];
    int          dly_h [DEPTH];

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int fmt(input logic [16:0] r, input bit offs, input bit flt);
        int v, m, e;
        if (!flt) begin
            v = int'(r[16:1]);
            if (offs) v = v ^ 32'h8000;
            if (v >= 32768) v = v - 65536;
            return v;
        end
        m = int'(r[16:3]);
        if (offs) m = m ^ 32'h2000;
        if (m >= 8192) m = m - 16384;
        e = int'(r[2:0]);
        v = m * (1 << e);
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic compare(input int c);
        int k, ev, eo, val;
        logic [16:0] pk;
        k = c - 2;
        if (k < 0) begin
            ev = 0;
            eo = prev_out;
        end else begin
            if (dly_h[k+1] == 0) pk = raw_h[k];
            else pk = (k >= 1) ? sel_h[k-1] : 17'd0;
            val = fmt(pk, offs_h[k+1], flt_h[k+1]);
            if (int_h[k+1]) begin
                ev = int'(run_h[k]);
                eo = acc_h[k] ? val : 0;
            end else begin
                ev = int'(acc_h[k]);
                eo = acc_h[k] ? val : prev_out;
            end
        end
        prev_out = eo;
        chk(cur_req, int'(smp_vld), ev, "R11 two-clock valid");
        chk(cur_req, int'($signed(smp_out)), eo, "R11 two-clock sample");
    endtask

    task automatic tick();
        logic [16:0] r;
        bit e, syn, pn;
        if (m_src < NB) begin
            r = bus_data[m_src*BW +: BW];
            e = !bus_en_n[m_src];
        end else begin
            r = m_tword;
            e = m_tlev | pulse_m;
        end
        raw_h[cyc]  = r;
        run_h[cyc]  = run_m;
        acc_h[cyc]  = run_m & e;
        int_h[cyc]  = m_interp;
        offs_h[cyc] = m_offs;
        flt_h[cyc]  = m_flt;
        dly_h[cyc]  = m_dly;
        if (m_dly > 0 && cyc >= m_dly && acc_h[cyc-m_dly]) sel_cur = r;
        sel_h[cyc] = sel_cur;
        syn = m_uloc ? sync_loc[m_lidx] : sync_glb;
        pn = cfg_we && cfg_addr == 2'd3 && cfg_wdata[1];
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin
                    m_src = int'(cfg_wdata[2:0]); m_interp = cfg_wdata[3];
                    m_offs = cfg_wdata[4]; m_flt = cfg_wdata[5];
                    m_dly = int'(cfg_wdata[8:6]); m_uloc = cfg_wdata[9];
                    m_lidx = int'(cfg_wdata[11:10]);
                end
                2'd1: m_tword[16:1] = cfg_wdata;
                2'd2: m_tword[0] = cfg_wdata[0];
                default: m_tlev = cfg_wdata[0];
            endcase
        end
        @(posedge clk);
        if (syn) run_m = 1;
        pulse_m = pn;
        @(negedge clk);
        cyc++;
        compare(cyc);
    endtask

    function automatic logic [15:0] ctrl(input int src, input bit ip, input bit ob,
                                         input bit fl, input int dly, input bit ul, input int li);
        return 16'(src) | (16'(ip) << 3) | (16'(ob) << 4) | (16'(fl) << 5)
             | (16'(dly) << 6) | (16'(ul) << 9) | (16'(li) << 10);
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        bus_en_n = '1;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rand_run(input int n, input int en_pct);
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < NB; b++) begin
                bus_data[b*BW +: BW] = 17'($urandom);
                bus_en_n[b] = (($urandom % 100) < en_pct) ? 1'b0 : 1'b1;
            end
            tick();
        end
        bus_en_n = '1;
    endtask

    task automatic tdm_frames(input int n, input int frames);
        for (int f = 0; f < frames; f++) begin
            for (int ch = 0; ch < 8; ch++) begin
                bus_data[0 +: BW] = 17'((f * 256 + n * 16 + ch + 1) << 1);
                bus_en_n[0] = (ch == 0) ? 1'b0 : 1'b1;
                tick();
            end
        end
        bus_en_n = '1;
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", int'(smp_vld), 0, "valid in reset");
            chk("R1", int'(smp_out), 0, "sample in reset");
        end
        rst_n = 1'b1;

        // R1/R6: enables before any sync are ignored
        cur_req = "R1";
        bus_en_n = '0;
        for (int i = 0; i < 4; i++) tick();
        chk("R1", int'(smp_vld), 0, "valid before sync");

        // R6: local sync index 2 selected; global and wrong local ignored
        cur_req = "R6";
        wr(0, ctrl(0, 0, 0, 0, 0, 1, 2));
        bus_en_n = '0;
        sync_glb = 1'b1; tick(); sync_glb = 1'b0;
        sync_loc = 4'b0010; tick(); sync_loc = '0;
        tick(); tick();
        chk("R6", int'(smp_vld), 0, "valid after unselected syncs");
        sync_loc = 4'b0100; tick(); sync_loc = '0;
        tick(); tick();
        chk("R6", int'(smp_vld), 1, "valid after selected sync");
        rand_run(10, 70);
        idle(10);

        // R4 and R3: gated timing on bus A, active-low enables
        cur_req = "R4";
        wr(0, ctrl(0, 0, 0, 0, 0, 0, 0));
        rand_run(60, 50);
        cur_req = "R3";
        rand_run(20, 0);
        chk("R3", int'(smp_vld), 0, "all enable pins high");
        rand_run(20, 100);
        idle(8);

        // R2: remaining sources
        cur_req = "R2";
        for (int s = 1; s < NB; s++) begin
            wr(0, ctrl(s, 0, 0, 0, 0, 0, 0));
            rand_run(30, 60);
            idle(8);
        end

        // R8: offset binary fixed point
        cur_req = "R8";
        wr(0, ctrl(0, 0, 1, 0, 0, 0, 0));
        rand_run(40, 60);
        idle(8);

        // R9: floating point, both encodings, saturation likely at large exponents
        cur_req = "R9";
        wr(0, ctrl(0, 0, 0, 1, 0, 0, 0));
        rand_run(60, 70);
        idle(8);
        wr(0, ctrl(0, 0, 1, 1, 0, 0, 0));
        rand_run(60, 70);
        idle(8);

        // R5: interpolated timing, zero stuffing
        cur_req = "R5";
        wr(0, ctrl(0, 1, 0, 0, 0, 0, 0));
        rand_run(50, 30);
        idle(6);
        chk("R5", int'(smp_vld), 1, "valid every clock");
        chk("R5", int'(smp_out), 0, "zero when idle");

        // R7: channel pick for every delay
        cur_req = "R7";
        for (int n = 0; n < 8; n++) begin
            idle(10);
            wr(0, ctrl(0, 0, 0, 0, n, 0, 0));
            tdm_frames(n, 4);
        end
        idle(10);
        wr(0, ctrl(0, 1, 0, 0, 5, 0, 0));
        tdm_frames(5, 3);
        idle(10);

        // R10: test word with strobe and level enable
        cur_req = "R10";
        wr(0, ctrl(4, 0, 0, 0, 0, 0, 0));
        wr(1, 16'h1234);
        wr(2, 16'h0001);
        wr(3, 16'h0002);
        idle(4);
        wr(1, 16'hC001);
        wr(3, 16'h0001);
        idle(5);
        wr(3, 16'h0000);
        idle(4);
        wr(0, ctrl(4, 1, 0, 0, 0, 0, 0));
        wr(3, 16'h0002);
        idle(5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule